// File: doc/BRIEF.md
# Multidrop-Capable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for a system-clock domain. One serial line goes out and one comes in. Each frame is a low start bit, five to eight data bits sent least significant bit first, an optional extra bit, and one or two high stop bits. The extra bit is either a parity bit or, in address-mark mode, a flag that tells address frames apart from data frames. Bit timing is derived from a 16-bit divisor, supplied as a high byte and a low byte, that drives a shared 16x oversampling tick.

The host writes words through a valid/ready transmit stream and reads words through a valid/ready receive stream. Each direction has one holding stage in front of, or behind, its shift register.

**Transmit stream rules.** `tx_ready` is high while the holding stage is empty. It is also high in the cycle the shifter takes the held word, so a new word can be accepted in that same cycle. A word transfers on any clock edge where both `tx_valid` and `tx_ready` are high.

**Receive stream rules.** `rx_valid` stays high and the received word stays stable until `rx_ready` is seen. If a frame completes while the word is still unread, the new frame is dropped and `rx_overrun` pulses.

In address-mark mode, the receiver passes data frames to the host only after an address frame that matches the station address. The two interrupt outputs reflect stream state, each gated by its own enable.

Top module: `uart_md`

## Requirements
- R1: `txd` idles high. A transmitted frame is, in order: one low start bit; `cfg_len`+5 data bits, least significant bit first (`cfg_len` 0..3 gives 5..8 bits); an extra bit when parity or address-mark mode is on; then one high stop bit, or two when `cfg_two_stop`=1.
- R2: `cfg_par`=1 selects even parity and `cfg_par`=2 selects odd parity; values 0 and 3 select no parity. The parity bit makes the count of ones over data plus parity even (for 1) or odd (for 2).
- R3: One bit lasts 16×D system clocks, where D = {`div_hi`,`div_lo`}. D=0 counts as 65536.
- R4: Transmit is double-buffered. A second word is accepted while the first is shifting. With `tx_valid` held high, consecutive frames follow with no idle time between the last stop bit and the next start bit.
- R5: The receiver samples each bit at its middle. A low pulse on `rxd` shorter than half a bit produces no word.
- R6: A received word carries `rx_perr`=1 when its parity bit is wrong (parity on, address-mark mode off) and `rx_ferr`=1 when any stop bit is sampled low.
- R7: The receive word holds until popped. A frame that completes while the holding stage is full and not being popped is dropped, pulses `rx_overrun` for one cycle, and leaves the held word unchanged.
- R8: With `cfg_mark_en`=1, the extra bit carries the address mark (1 = address frame). Parity is neither sent nor checked, and `rx_mark` reports the mark of the received word.
- R9: With `cfg_mark_en`=1, data frames are discarded until an address frame whose data equals `cfg_station` arrives. That address frame and the data frames after it are delivered. Any non-matching address frame is discarded and stops delivery again. After reset nothing is selected.
- R10: `tx_irq` = `tx_irq_en` AND `tx_ready`, and `rx_irq` = `rx_irq_en` AND `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_hi | input | 8 | Upper byte of the bit-rate divisor |
| div_lo | input | 8 | Lower byte of the bit-rate divisor |
| cfg_len | input | 2 | Data length code, bits = value + 5 |
| cfg_par | input | 2 | Parity: 1 even, 2 odd, 0/3 none |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_mark_en | input | 1 | Address-mark mode enable |
| cfg_station | input | 8 | Own station address |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_data | input | 8 | Word to send |
| tx_mark | input | 1 | Address mark to send with the word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit holding stage can take a word |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received word |
| rx_mark | output | 1 | Address mark of the received word |
| rx_perr | output | 1 | Parity error on the received word |
| rx_ferr | output | 1 | Framing error on the received word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Host takes the received word |
| rx_overrun | output | 1 | One-cycle pulse when a frame is lost |
| tx_irq | output | 1 | Masked transmit interrupt |
| rx_irq | output | 1 | Masked receive interrupt |

## Verification
Two transmit events can land on the same edge: the shifter takes the held word at the end of a frame, and the host pushes a new word into the holding stage. The bench provokes this by keeping `tx_valid` high over three words, so the second and third words are accepted exactly as the shifter empties the holding stage. The decoded frames must come out in push order, and each start edge must follow the middle of the previous stop bit by exactly half a bit. Address filtering is judged through a sequence of selected, non-selected and unaddressed frames, observing which ones reach the receive stream.

// File: rtl/uart_md_pkg.sv
package uart_md_pkg;
  localparam int FRAME_MAX = 12;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return {2'b00, len} + 4'd5;
  endfunction

  function automatic logic [7:0] data_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic has_extra(input logic mark_en, input logic [1:0] par);
    return mark_en || (par == PAR_EVEN) || (par == PAR_ODD);
  endfunction

  function automatic logic [3:0] frame_len(input logic [1:0] len, input logic mark_en,
                                           input logic [1:0] par, input logic two_stop);
    return 4'd1 + data_bits(len) + {3'b000, has_extra(mark_en, par)} + (two_stop ? 4'd2 : 4'd1);
  endfunction
endpackage

// File: rtl/uart_md_baud.sv
module uart_md_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = (div == '0) ? (CNT_W'(1) << DIV_W) : {1'b0, div};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= limit - CNT_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      tick <= 1'b0;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (div != DIV_W'(1)) && $stable(div) |=> !tick); // R3
endmodule

// File: rtl/uart_md_tx.sv
module uart_md_tx
  import uart_md_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   cfg_len,
  input  logic [1:0]   cfg_par,
  input  logic         cfg_two_stop,
  input  logic         cfg_mark_en,
  input  logic [W-1:0] tx_data,
  input  logic         tx_mark,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic         txd
);
  localparam int BODY_W = FRAME_MAX - 1;

  logic                 hold_full, hold_mark;
  logic [W-1:0]         hold_data;
  logic                 busy;
  logic [FRAME_MAX-1:0] sh;
  logic [3:0]           bits_left, sub;
  logic                 take, push, last_edge, extbit;
  logic [W-1:0]         dm;
  logic [BODY_W-1:0]    body;
  logic [2:0]           tail;
  logic [3:0]           nd;

  assign last_edge = busy && (sub == 4'd15) && (bits_left == 4'd1);
  assign take      = tick && hold_full && (!busy || last_edge);
  assign tx_ready  = !hold_full || take;
  assign push      = tx_valid && tx_ready;
  assign txd       = busy ? sh[0] : 1'b1;

  always_comb begin
    nd     = data_bits(cfg_len);
    dm     = hold_data & data_mask(cfg_len);
    extbit = cfg_mark_en ? hold_mark : ((cfg_par == PAR_ODD) ? ~^dm : ^dm);
    tail   = has_extra(cfg_mark_en, cfg_par) ? {2'b11, extbit} : 3'b111;
    body   = ({{(BODY_W-3){1'b1}}, tail} << nd) | {{(BODY_W-W){1'b0}}, dm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      hold_mark <= 1'b0;
    end else if (push) begin
      hold_full <= 1'b1;
      hold_data <= tx_data;
      hold_mark <= tx_mark;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sh        <= '1;
      bits_left <= '0;
      sub       <= '0;
    end else if (take) begin
      busy      <= 1'b1;
      sh        <= {body, 1'b0};
      bits_left <= frame_len(cfg_len, cfg_mark_en, cfg_par, cfg_two_stop);
      sub       <= '0;
    end else if (busy && tick) begin
      sub <= sub + 4'd1;
      if (sub == 4'd15) begin
        sh        <= {1'b1, sh[FRAME_MAX-1:1]};
        bits_left <= bits_left - 4'd1;
        if (bits_left == 4'd1) busy <= 1'b0;
      end
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd); // R1
  AST_TX_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && !take |=> hold_full && $stable(hold_data)); // R4
endmodule

// File: rtl/uart_md_rx.sv
module uart_md_rx
  import uart_md_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         rxd,
  input  logic [1:0]   cfg_len,
  input  logic [1:0]   cfg_par,
  input  logic         cfg_two_stop,
  input  logic         cfg_mark_en,
  input  logic         accept,
  output logic         fin,
  output logic [W-1:0] dat,
  output logic         ext,
  output logic [W-1:0] rx_data,
  output logic         rx_mark,
  output logic         rx_perr,
  output logic         rx_ferr,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic         rx_overrun
);
  logic [1:0] sync;
  logic       rxs, ferr, perr;
  rx_st_t     st;
  logic [3:0] sub, idx, nd, flen;

  assign rxs  = sync[1];
  assign nd   = data_bits(cfg_len);
  assign flen = frame_len(cfg_len, cfg_mark_en, cfg_par, cfg_two_stop);
  assign perr = !cfg_mark_en && ((cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD)) &&
                ((^dat ^ ext) != (cfg_par == PAR_ODD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; sub <= '0; idx <= '0; dat <= '0;
      ext <= 1'b0; ferr <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (tick) begin
        unique case (st)
          RX_IDLE: if (!rxs) begin
            st  <= RX_START;
            sub <= '0;
          end
          RX_START: if (sub == 4'd7) begin
            if (!rxs) begin
              st <= RX_BITS; sub <= '0; idx <= '0;
              dat <= '0; ext <= 1'b0; ferr <= 1'b0;
            end else begin
              st <= RX_IDLE;
            end
          end else begin
            sub <= sub + 4'd1;
          end
          RX_BITS: begin
            sub <= sub + 4'd1;
            if (sub == 4'd15) begin
              if (idx < nd)                                                 dat[idx[2:0]] <= rxs;
              else if ((idx == nd) && has_extra(cfg_mark_en, cfg_par))      ext <= rxs;
              else if (!rxs)                                                ferr <= 1'b1;
              idx <= idx + 4'd1;
              if (idx == flen - 4'd2) begin
                st  <= RX_IDLE;
                fin <= 1'b1;
              end
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0; rx_mark <= 1'b0;
      rx_perr <= 1'b0; rx_ferr <= 1'b0; rx_overrun <= 1'b0;
    end else begin
      rx_overrun <= 1'b0;
      if (fin && accept) begin
        if (!rx_valid || rx_ready) begin
          rx_valid <= 1'b1;
          rx_data  <= dat;
          rx_mark  <= cfg_mark_en && ext;
          rx_perr  <= perr;
          rx_ferr  <= ferr;
        end else begin
          rx_overrun <= 1'b1;
        end
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R7
  AST_RX_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $past(rx_valid && !rx_ready)); // R7
endmodule

// File: rtl/uart_md_filter.sv
module uart_md_filter
  import uart_md_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fin,
  input  logic [W-1:0] dat,
  input  logic         ext,
  input  logic         cfg_mark_en,
  input  logic [1:0]   cfg_len,
  input  logic [W-1:0] cfg_station,
  output logic         accept
);
  logic listening, match;

  assign match  = (dat == (cfg_station & data_mask(cfg_len)));
  assign accept = !cfg_mark_en || (ext ? match : listening);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         listening <= 1'b0;
    else if (fin && cfg_mark_en && ext) listening <= match;
  end

  AST_LISTEN_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fin && cfg_mark_en && ext && match |=> listening); // R9
  AST_DEAF_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    fin && cfg_mark_en && ext && !match |=> !listening); // R9
endmodule

// File: rtl/uart_md.sv
module uart_md #(
  parameter int W     = 8,
  parameter int DIV_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   div_hi,
  input  logic [7:0]   div_lo,
  input  logic [1:0]   cfg_len,
  input  logic [1:0]   cfg_par,
  input  logic         cfg_two_stop,
  input  logic         cfg_mark_en,
  input  logic [W-1:0] cfg_station,
  input  logic         tx_irq_en,
  input  logic         rx_irq_en,
  input  logic [W-1:0] tx_data,
  input  logic         tx_mark,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic         txd,
  input  logic         rxd,
  output logic [W-1:0] rx_data,
  output logic         rx_mark,
  output logic         rx_perr,
  output logic         rx_ferr,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic         rx_overrun,
  output logic         tx_irq,
  output logic         rx_irq
);
  logic         tick, fin, ext, accept;
  logic [W-1:0] dat;

  uart_md_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(DIV_W'({div_hi, div_lo})), .tick(tick));

  uart_md_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_two_stop(cfg_two_stop), .cfg_mark_en(cfg_mark_en), .tx_data(tx_data),
    .tx_mark(tx_mark), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd));

  uart_md_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .cfg_mark_en(cfg_mark_en),
    .accept(accept), .fin(fin), .dat(dat), .ext(ext), .rx_data(rx_data),
    .rx_mark(rx_mark), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun));

  uart_md_filter #(.W(W)) u_filter (
    .clk(clk), .rst_n(rst_n), .fin(fin), .dat(dat), .ext(ext),
    .cfg_mark_en(cfg_mark_en), .cfg_len(cfg_len), .cfg_station(cfg_station),
    .accept(accept));

  assign tx_irq = tx_irq_en && tx_ready;
  assign rx_irq = rx_irq_en && rx_valid;

  AST_RX_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && rx_irq_en |-> rx_irq); // R10
endmodule

// File: tb/uart_md_bench.sv
`timescale 1ns/1ps
module uart_md_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [7:0] div_hi, div_lo, cfg_station, tx_data, rx_data;
  logic [1:0] cfg_len, cfg_par;
  logic       cfg_two_stop, cfg_mark_en, tx_irq_en, rx_irq_en, tx_mark, tx_valid;
  logic       tx_ready, txd, rxd, rx_mark, rx_perr, rx_ferr, rx_valid, rx_ready;
  logic       rx_overrun, tx_irq, rx_irq;

  int checks = 0, errors = 0, bt = 16, ovr_cnt = 0;

  uart_md u_uart_md (.*);

  always @(negedge clk) if (rx_overrun) ovr_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbits();
    return 32'(cfg_len) + 5;
  endfunction
  function automatic bit extra_on();
    return cfg_mark_en || cfg_par == 2'd1 || cfg_par == 2'd2;
  endfunction
  function automatic logic par_of(input logic [7:0] d);
    logic p = 1'b0;
    for (int i = 0; i < nbits(); i++) p ^= d[i];
    return (cfg_par == 2'd2) ? ~p : p;
  endfunction
  function automatic logic [7:0] msk(input logic [7:0] d);
    return d & 8'((9'h100 >> (8 - nbits())) - 1);
  endfunction

  task automatic push(input logic [7:0] d, input logic m);
    tx_data = d; tx_mark = m; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic grab(output logic [7:0] d, output logic e, output bit ok, output int gap);
    gap = 0; d = '0; e = 1'b1; ok = 1;
    while (txd !== 1'b0) begin @(negedge clk); gap++; end
    repeat (bt/2) @(negedge clk);
    if (txd !== 1'b0) ok = 0;
    for (int i = 0; i < nbits(); i++) begin repeat (bt) @(negedge clk); d[i] = txd; end
    if (extra_on()) begin repeat (bt) @(negedge clk); e = txd; end
    for (int s = 0; s < (cfg_two_stop ? 2 : 1); s++) begin
      repeat (bt) @(negedge clk);
      if (txd !== 1'b1) ok = 0;
    end
  endtask

  task automatic send(input logic [7:0] d, input logic e, input bit bad_stop);
    rxd = 1'b0; repeat (bt) @(negedge clk);
    for (int i = 0; i < nbits(); i++) begin rxd = d[i]; repeat (bt) @(negedge clk); end
    if (extra_on()) begin rxd = e; repeat (bt) @(negedge clk); end
    for (int s = 0; s < (cfg_two_stop ? 2 : 1); s++) begin
      rxd = (s == 0 && bad_stop) ? 1'b0 : 1'b1; repeat (bt) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop();
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] d, g; logic e; bit ok; int gap;
    logic [7:0] seq [3];
    void'($urandom(32'd4242));
    rst_n = 1'b0; div_hi = 8'd0; div_lo = 8'd1; cfg_len = 2'd3; cfg_par = 2'd0;
    cfg_two_stop = 1'b0; cfg_mark_en = 1'b0; cfg_station = 8'h5A; tx_irq_en = 1'b0;
    rx_irq_en = 1'b0; tx_data = '0; tx_mark = 1'b0; tx_valid = 1'b0; rxd = 1'b1; rx_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state (R1, R10)
    chk(txd === 1'b1, "R1 idle line high", 32'(txd), 1);
    chk(tx_ready === 1'b1 && rx_valid === 1'b0, "R4 reset ready/valid", {tx_ready, rx_valid}, 2'b10);
    chk(tx_irq === 1'b0, "R10 tx_irq masked", 32'(tx_irq), 0);
    tx_irq_en = 1'b1; @(negedge clk);
    chk(tx_irq === 1'b1, "R10 tx_irq enabled", 32'(tx_irq), 1);
    tx_irq_en = 1'b0;

    // random transmit frames (R1, R2)
    for (int k = 0; k < 12; k++) begin
      cfg_len = 2'($urandom % 4); cfg_par = 2'($urandom % 4); cfg_two_stop = 1'($urandom % 2);
      d = 8'($urandom);
      fork push(d, 1'b0); grab(g, e, ok, gap); join
      chk(g === msk(d), "R1 tx data bits", g, msk(d));
      chk(ok, "R1 tx start/stop levels", 32'(ok), 1);
      if (extra_on()) chk(e === par_of(d), "R2 tx parity bit", e, par_of(d));
    end

    // random receive frames (R1, R2, R6)
    for (int k = 0; k < 12; k++) begin
      cfg_len = 2'($urandom % 4); cfg_par = 2'($urandom % 4); cfg_two_stop = 1'($urandom % 2);
      d = 8'($urandom);
      send(d, par_of(d), 1'b0);
      chk(rx_valid === 1'b1 && rx_data === msk(d), "R1 rx word", rx_data, msk(d));
      chk(rx_perr === 1'b0 && rx_ferr === 1'b0, "R6 rx clean flags", {rx_perr, rx_ferr}, 0);
      pop();
    end

    // parity error and framing error (R6)
    cfg_len = 2'd3; cfg_par = 2'd2; cfg_two_stop = 1'b0;
    send(8'hA5, ~par_of(8'hA5), 1'b0);
    chk(rx_perr === 1'b1 && rx_ferr === 1'b0, "R6 parity error flagged", {rx_perr, rx_ferr}, 2'b10);
    pop();
    cfg_par = 2'd0;
    send(8'h3C, 1'b0, 1'b1);
    chk(rx_ferr === 1'b1 && rx_data === 8'h3C, "R6 framing error flagged", {rx_ferr, rx_data}, 9'h13C);
    pop(); repeat (bt * 2) @(negedge clk);
    if (rx_valid) pop();

    // false start then a real frame (R5)
    rxd = 1'b0; repeat (bt/4) @(negedge clk); rxd = 1'b1;
    repeat (bt * 2) @(negedge clk);
    chk(rx_valid === 1'b0, "R5 short low pulse ignored", 32'(rx_valid), 0);
    send(8'h81, 1'b0, 1'b0);
    chk(rx_valid === 1'b1 && rx_data === 8'h81, "R5 mid-bit sampling", rx_data, 8'h81);

    // receive interrupt mask (R10)
    chk(rx_irq === 1'b0, "R10 rx_irq masked", 32'(rx_irq), 0);
    rx_irq_en = 1'b1; @(negedge clk);
    chk(rx_irq === 1'b1, "R10 rx_irq enabled", 32'(rx_irq), 1);
    rx_irq_en = 1'b0;

    // overrun: second frame while full (R7)
    ovr_cnt = 0;
    send(8'h77, 1'b0, 1'b0);
    chk(ovr_cnt == 1, "R7 overrun pulse", ovr_cnt, 1);
    chk(rx_data === 8'h81 && rx_valid === 1'b1, "R7 held word kept", rx_data, 8'h81);
    pop();
    chk(rx_valid === 1'b0, "R7 pop empties holding", 32'(rx_valid), 0);

    // back-to-back transmit with push on the take edge (R4)
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_two_stop = 1'b0;
    seq[0] = 8'h12; seq[1] = 8'hE7; seq[2] = 8'h5C;
    fork
      begin push(seq[0], 1'b0); push(seq[1], 1'b0); push(seq[2], 1'b0); end
      begin
        for (int k = 0; k < 3; k++) begin
          grab(g, e, ok, gap);
          chk(g === seq[k], "R4 back-to-back order", g, seq[k]);
          if (k > 0) chk(gap == bt/2, "R4 no idle gap", gap, bt/2);
        end
      end
    join

    // address-mark transmit (R8)
    cfg_mark_en = 1'b1;
    fork push(8'hC3, 1'b1); grab(g, e, ok, gap); join
    chk(e === 1'b1 && g === 8'hC3, "R8 tx mark bit", {e, g}, 9'h1C3);

    // address filtering (R8, R9)
    send(8'h11, 1'b0, 1'b0);
    chk(rx_valid === 1'b0, "R9 data dropped before selection", 32'(rx_valid), 0);
    send(8'h33, 1'b1, 1'b0);
    chk(rx_valid === 1'b0, "R9 foreign address dropped", 32'(rx_valid), 0);
    send(8'h5A, 1'b1, 1'b0);
    chk(rx_valid === 1'b1 && rx_mark === 1'b1 && rx_data === 8'h5A, "R8 own address delivered",
        {rx_mark, rx_data}, 9'h15A);
    pop();
    send(8'h22, 1'b0, 1'b0);
    chk(rx_valid === 1'b1 && rx_mark === 1'b0 && rx_data === 8'h22, "R9 data after match",
        {rx_mark, rx_data}, 9'h022);
    pop();
    send(8'h44, 1'b1, 1'b0);
    send(8'h23, 1'b0, 1'b0);
    chk(rx_valid === 1'b0, "R9 deselected by other address", 32'(rx_valid), 0);
    cfg_mark_en = 1'b0;

    // divisor byte order and bit time (R3)
    div_hi = 8'h01; div_lo = 8'h02; bt = 16 * 258;
    repeat (600) @(negedge clk);
    cfg_len = 2'd3; cfg_par = 2'd0;
    push(8'hFF, 1'b0);
    while (txd !== 1'b0) @(negedge clk);
    gap = 0;
    while (txd === 1'b0) begin gap++; @(negedge clk); end
    chk(gap == bt, "R3 bit time 16*D", gap, bt);
    repeat (bt * 10) @(negedge clk);
    finish_run();
  end
endmodule